// File: doc/BRIEF.md
# Two-Rate Phase-Accumulator Waveform Generator

This block is a direct digital synthesis source. Each strobe on `sample_en` moves a 32-bit signed phase accumulator forward and yields one signed 16-bit sample. The sample is shaped as a cosine, a square or a triangle, then scaled by a signed amplitude. The amount the accumulator advances depends on the accumulator's own sign. While the accumulator is non-negative it adds `tw_pos`. While it is negative it adds `tw_neg`. The two halves of each period can therefore last different numbers of samples, which sets the symmetry of the triangle or the duty of the square.

A controller computes the two step sizes from a target frequency and symmetry and writes them on the step inputs. It then strobes the enable once per output sample. The step inputs, the waveform select and the amplitude may change between strobes. Each new value applies from the next strobe onward.

Top module: `dds_waveform_gen`

## Requirements
- R1: After reset, and while the asynchronous reset is held, `sample_valid` is 0 and `sample_out` is 0. The accumulator starts at 0.
- R2: A strobe on `sample_en` while `clr` is low produces one sample. That sample appears on `sample_out` with `sample_valid` high during the single clock cycle after the strobe edge. In every other cycle `sample_valid` is low.
- R3: On each strobe the accumulator wraps modulo 2^32. It adds the saturated `tw_neg` when its value before the strobe is negative (bit 31 set), and the saturated `tw_pos` otherwise.
- R4: Each step input is limited to 2^31 before use. A step of 0xFFFFFFFF therefore behaves as 0x80000000, and the sign flips on every strobe.
- R5: Square (`wave_sel` = 1) uses the sign from before the strobe. The output is `-amplitude` (truncated to 16 bits) when that sign is negative, and `amplitude` otherwise. An amplitude of -32768 gives -32768 in both halves.
- R6: Triangle (`wave_sel` = 2) uses the accumulator after the strobe. The scale is |acc >>> 15| - 32768.
- R7: Cosine (`wave_sel` = 0) uses the accumulator after the strobe. Its bits [31:30] select the quadrant and bits [29:22] form the index i. The table holds T(i) = floor(32767*cos(pi/2*(i+0.5)/256) + 0.5). The scale is T(i), -T(255-i), -T(i) and T(255-i) for quadrants 0 to 3 in that order.
- R8: For every waveform the sample is bits [15:0] of (amplitude * scale) >>> 15, with no rounding offset. `wave_sel` = 3 gives a scale of 0.
- R9: With both steps equal to 2^(32-k), the output sequence repeats exactly every 2^k strobes.
- R10: `clr` high at a clock edge sets the accumulator to 0 and produces no sample, even when `sample_en` is high at the same edge. Cycles without a strobe leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear, has priority over the strobe |
| sample_en | input | 1 | One-cycle strobe requesting one sample |
| wave_sel | input | 2 | 0 cosine, 1 square, 2 triangle, 3 silent |
| amplitude | input | 16 | Signed output scale |
| tw_pos | input | 32 | Step added while the accumulator is non-negative |
| tw_neg | input | 32 | Step added while the accumulator is negative |
| sample_out | output | 16 | Signed sample, registered |
| sample_valid | output | 1 | High for the cycle holding a new sample |

## Verification
A wrong accumulator value shows up in the very next sample. The triangle and cosine expose the accumulator's upper bits almost directly, and the square exposes its sign. The bench therefore checks every sample of full periods against an arithmetic model rather than only spot values. A wrong choice of step shows up within one half-period, as a square whose transitions land on the wrong strobe. Strobes that are skipped or duplicated, and a stale accumulator after a clear, show up on the first sample that follows.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  typedef enum logic [1:0] {
    WAVE_COS  = 2'd0,
    WAVE_SQR  = 2'd1,
    WAVE_TRI  = 2'd2,
    WAVE_NONE = 2'd3
  } wave_e;

  localparam int ACC_W   = 32;
  localparam int SMP_W   = 16;
  localparam int SCALE_W = SMP_W + 2;
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [ACC_W-1:0] tw_pos,
  input  logic [ACC_W-1:0] tw_neg,
  output logic             sign_before,
  output logic [ACC_W-1:0] acc_after
);
  localparam logic [ACC_W-1:0] NYQ = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] pos_lim, neg_lim, step;

  always_comb begin
    pos_lim     = (tw_pos > NYQ) ? NYQ : tw_pos;
    neg_lim     = (tw_neg > NYQ) ? NYQ : tw_neg;
    sign_before = acc_q[ACC_W-1];
    step        = sign_before ? neg_lim : pos_lim;
    acc_after   = acc_q + step;
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_after;
    else         acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(acc_q));
endmodule

// File: rtl/dds_cos_rom.sv
`timescale 1ns/1ps
module dds_cos_rom #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 8,
  parameter int VAL_W = 16
) (
  input  logic [ACC_W-1:0]        phase,
  output logic signed [VAL_W-1:0] cos_val
);
  localparam int DEPTH = 1 << IDX_W;
  localparam real HALF_PI = 1.5707963267948966;
  localparam real PEAK = real'((1 << (VAL_W-1)) - 1);

  logic [VAL_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam real ANG = HALF_PI * (real'(i) + 0.5) / real'(DEPTH);
    localparam int  VAL = $rtoi($floor(PEAK * $cos(ANG) + 0.5));
    assign rom[i] = VAL[VAL_W-1:0];
  end

  logic [1:0]       quad;
  logic [IDX_W-1:0] idx, addr;
  logic signed [VAL_W-1:0] mag;

  always_comb begin
    quad = phase[ACC_W-1 -: 2];
    idx  = phase[ACC_W-3 -: IDX_W];
    addr = quad[0] ? ~idx : idx;
    mag  = $signed(rom[addr]);
    cos_val = (quad == 2'd1 || quad == 2'd2) ? -mag : mag;
  end
endmodule

// File: rtl/dds_shaper.sv
`timescale 1ns/1ps
module dds_shaper
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int SMP_W = 16
) (
  input  logic [1:0]              wave_sel,
  input  logic signed [SMP_W-1:0] amplitude,
  input  logic                    sign_before,
  input  logic [ACC_W-1:0]        acc_after,
  input  logic signed [SMP_W-1:0] cos_val,
  output logic [SMP_W-1:0]        sample
);
  localparam int SC_W   = SMP_W + 2;
  localparam int PROD_W = SC_W + SMP_W;
  localparam int SH     = SMP_W - 1;
  localparam int TRI_SH = ACC_W - SMP_W - 1;
  localparam logic signed [SC_W-1:0] FULL = SC_W'(1 << SH);

  logic signed [ACC_W-1:0]  acc_s, tri_sh;
  logic signed [SC_W-1:0]   tri_v, tri_abs, scale;
  logic signed [PROD_W-1:0] prod, shifted;

  always_comb begin
    acc_s   = $signed(acc_after);
    tri_sh  = acc_s >>> TRI_SH;
    tri_v   = tri_sh[SC_W-1:0];
    tri_abs = tri_v[SC_W-1] ? -tri_v : tri_v;
    unique case (wave_e'(wave_sel))
      WAVE_COS: scale = SC_W'(cos_val);
      WAVE_SQR: scale = sign_before ? -FULL : FULL;
      WAVE_TRI: scale = tri_abs - FULL;
      default:  scale = '0;
    endcase
    prod    = PROD_W'(amplitude) * PROD_W'(scale);
    shifted = prod >>> SH;
    sample  = shifted[SMP_W-1:0];
  end
endmodule

// File: rtl/dds_waveform_gen.sv
`timescale 1ns/1ps
module dds_waveform_gen
  import dds_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16,
  parameter int ROM_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sample_en,
  input  logic [1:0]         wave_sel,
  input  logic [OUT_W-1:0]   amplitude,
  input  logic [PHASE_W-1:0] tw_pos,
  input  logic [PHASE_W-1:0] tw_neg,
  output logic [OUT_W-1:0]   sample_out,
  output logic               sample_valid
);
  logic rst_meta, rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  logic                    take;
  logic                    sign_before;
  logic [PHASE_W-1:0]      acc_after;
  logic signed [OUT_W-1:0] cos_val;
  logic [OUT_W-1:0]        sample_d, out_d;
  logic                    valid_d;

  assign take = sample_en && !clr;

  dds_phase_acc #(.ACC_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_int), .clr(clr), .en(sample_en),
    .tw_pos(tw_pos), .tw_neg(tw_neg),
    .sign_before(sign_before), .acc_after(acc_after)
  );

  dds_cos_rom #(.ACC_W(PHASE_W), .IDX_W(ROM_AW), .VAL_W(OUT_W)) u_rom (
    .phase(acc_after), .cos_val(cos_val)
  );

  dds_shaper #(.ACC_W(PHASE_W), .SMP_W(OUT_W)) u_shape (
    .wave_sel(wave_sel), .amplitude($signed(amplitude)),
    .sign_before(sign_before), .acc_after(acc_after),
    .cos_val(cos_val), .sample(sample_d)
  );

  always_comb begin
    valid_d = take;
    out_d   = take ? sample_d : sample_out;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_out   <= out_d;
      sample_valid <= valid_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_int)
    take |=> sample_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !take |=> !sample_valid);
  // R5
  square_level_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (take && wave_sel == 2'd1) |=>
      (sample_out == $past(amplitude) ||
       sample_out == OUT_W'(-$signed($past(amplitude)))));
endmodule

// File: tb/dds_waveform_gen_test.sv
`timescale 1ns/1ps
module dds_waveform_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        sample_en = 1'b0;
  logic [1:0]  wave_sel = 2'd0;
  logic [15:0] amplitude = 16'd0;
  logic [31:0] tw_pos = 32'd0;
  logic [31:0] tw_neg = 32'd0;
  logic [15:0] sample_out;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_acc = 32'd0;

  always #2 clk = ~clk;

  dds_waveform_gen uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sample_en(sample_en),
    .wave_sel(wave_sel), .amplitude(amplitude), .tw_pos(tw_pos),
    .tw_neg(tw_neg), .sample_out(sample_out), .sample_valid(sample_valid)
  );

  function automatic logic [31:0] lim(input logic [31:0] w);
    return (w > 32'h8000_0000) ? 32'h8000_0000 : w;
  endfunction

  function automatic int tab(input int i);
    return $rtoi($floor(32767.0 * $cos(1.5707963267948966 * (real'(i) + 0.5) / 256.0) + 0.5));
  endfunction

  function automatic int cosv(input logic [31:0] a);
    int q = int'(a[31:30]);
    int i = int'(a[29:22]);
    case (q)
      0: return tab(i);
      1: return -tab(255 - i);
      2: return -tab(i);
      default: return tab(255 - i);
    endcase
  endfunction

  // Advances the model accumulator and returns the expected sample.
  function automatic logic [15:0] model();
    logic sgn = m_acc[31];
    longint sc, p;
    int t;
    m_acc = m_acc + (sgn ? lim(tw_neg) : lim(tw_pos));
    case (wave_sel)
      2'd0: sc = cosv(m_acc);
      2'd1: sc = sgn ? -32768 : 32768;
      2'd2: begin
        t  = $signed(m_acc) >>> 15;
        sc = ((t < 0) ? -t : t) - 32768;
      end
      default: sc = 0;
    endcase
    p = longint'($signed(amplitude)) * sc;
    p = p >>> 15;
    return p[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic one_sample(input string req, output logic [15:0] got);
    logic [15:0] e;
    @(negedge clk);
    sample_en = 1'b1;
    e = model();
    @(negedge clk);
    sample_en = 1'b0;
    got = sample_out;
    chk({req, " valid"}, 32'(sample_valid), 32'd1);
    chk(req, 32'(sample_out), 32'(e));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    logic [15:0] first16 [16];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(sample_valid), 32'd0);
    chk("R1 out in reset", 32'(sample_out), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", 32'(sample_valid), 32'd0);
    chk("R1 out after reset", 32'(sample_out), 32'd0);

    // R7 R8: full cosine period, several amplitudes
    tw_pos = 32'h0100_0000; tw_neg = 32'h0100_0000;
    wave_sel = 2'd0;
    foreach (amplitude[k]) ;
    for (int a = 0; a < 3; a++) begin
      amplitude = (a == 0) ? 16'h7FFF : (a == 1) ? 16'h8000 : 16'h1234;
      for (int n = 0; n < 256; n++) one_sample("R7 cosine", s);
    end

    // R6 R8: triangle with amplitude sweep
    wave_sel = 2'd2;
    tw_pos = 32'h0200_0000; tw_neg = 32'h0080_0000;
    for (int a = -32768; a < 32768; a += 4099) begin
      amplitude = 16'(a);
      for (int n = 0; n < 24; n++) one_sample("R6 triangle", s);
    end

    // R3 R5: asymmetric square, duty set by the two steps
    wave_sel = 2'd1;
    tw_pos = 32'h1000_0000; tw_neg = 32'h4000_0000;
    amplitude = 16'd1000;
    for (int n = 0; n < 40; n++) one_sample("R3 R5 square", s);
    amplitude = 16'h8000;
    for (int n = 0; n < 8; n++) one_sample("R5 square min amplitude", s);

    // R4: saturated steps flip the sign every strobe
    tw_pos = 32'hFFFF_FFFF; tw_neg = 32'hC000_0000;
    amplitude = 16'd300;
    for (int n = 0; n < 8; n++) one_sample("R4 saturated step", s);

    // R8: silent selection
    wave_sel = 2'd3;
    for (int n = 0; n < 4; n++) one_sample("R8 silent", s);

    // R10: clear, also with a strobe at the same edge
    @(negedge clk);
    clr = 1'b1; sample_en = 1'b1;
    @(negedge clk);
    clr = 1'b0; sample_en = 1'b0;
    m_acc = 32'd0;
    chk("R10 no sample on clear", 32'(sample_valid), 32'd0);

    // R9: period of 16 strobes with step 2^28
    wave_sel = 2'd2; amplitude = 16'd20000;
    tw_pos = 32'h1000_0000; tw_neg = 32'h1000_0000;
    for (int n = 0; n < 16; n++) begin
      one_sample("R9 first period", s);
      first16[n] = s;
    end
    for (int n = 0; n < 16; n++) begin
      one_sample("R9 second period", s);
      chk("R9 repeat", 32'(s), 32'(first16[n]));
    end

    // R2 R10: idle cycles keep valid low and the phase frozen
    repeat (5) begin
      @(negedge clk);
      chk("R2 idle valid", 32'(sample_valid), 32'd0);
    end
    for (int n = 0; n < 4; n++) one_sample("R10 resume after idle", s);

    // R3: step change applies at the next strobe
    wave_sel = 2'd0;
    tw_pos = 32'h0345_6789; tw_neg = 32'h0011_2233;
    for (int n = 0; n < 64; n++) one_sample("R3 new steps", s);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule